// File: doc/BRIEF.md
# Paeth Wavefront Block Decoder

This block turns a square tile of one-byte residuals back into the original samples, where each residual was formed by subtracting a Paeth prediction from the sample. The prediction uses three neighbours that have already been rebuilt: the one to the left, the one above, and the one above and to the left. A sample therefore cannot be rebuilt until those three neighbours are done. Samples on the same anti-diagonal do not depend on each other, so they are rebuilt together.

There is one predictor lane per row. Each lane takes two clock cycles per sample. A lane starts one anti-diagonal, which is two cycles, later than the row above it. The whole tile is loaded in parallel with a one-cycle start pulse. The rebuilt tile is held on a wide output bus, and a one-cycle done flag marks completion. The finish time is fixed and does not depend on the data.

Top module: `paeth_wave_decoder`

## Requirements
- R1: After reset, every byte of `tile_o` is zero and `done_o` is low.
- R2: The prediction is computed as follows. Let a be the left neighbour, b the upper neighbour and c the upper-left neighbour. The prediction is a if |b-c| <= |a-c| and |b-c| <= |a+b-2c|. Otherwise it is b if |a-c| <= |a+b-2c|. Otherwise it is c. These differences are evaluated without overflow. Each output byte equals its residual plus the prediction, modulo 256.
- R3: Neighbours that fall outside the tile, in row -1 or column -1, count as zero.
- R4: Count the edge that samples `start_i` as edge 0. The sample at row r, column c appears on `tile_o` after edge 2(r+c)+2, and not before. With the default size, the last sample appears after edge 30.
- R5: `done_o` is high for exactly one cycle, the cycle after edge 30, which is the edge that writes the last sample.
- R6: A `start_i` pulse that arrives while a tile is being rebuilt is ignored. The tile in progress finishes with its own residuals, and its timing is unchanged.
- R7: Byte layout: the sample at row r, column c is held at bits [8*(8r+c) +: 8], in both `resid_i` and `tile_o`. Residuals are captured on edge 0, so later changes on `resid_i` have no effect.
- R8: A new start is accepted in the cycle in which `done_o` is high, so tiles can run back to back. The rebuilt tile stays on `tile_o` until the next tile overwrites it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts a tile |
| resid_i | input | 512 | Residual bytes, row-major |
| tile_o | output | 512 | Rebuilt samples, row-major |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench uses four kinds of residual tile, each compared with a serial reference model:
- All-zero tiles test the zero-neighbour rule at the edges.
- All-0xFF tiles make the sums wrap modulo 256 and make a, b and c tie often, which tests the fixed tie order.
- Tiles of small residuals build smooth ramps, where the choice between b and c changes from sample to sample.
- Fully random tiles reach every branch of the selection.

Timing is tested by sampling the first sample just after it is written and the last sample just before it is written. A start pulse with different residuals, sent in the middle of a tile, tests that a start while busy is ignored.

// File: rtl/pwd_pkg.sv
// Shared types for the Paeth wavefront decoder.
// Assumes one-byte samples. Differences use a 10-bit signed width so that
// a+b-2c (range -510..510) cannot overflow.
package pwd_pkg;
    localparam int SMP_W  = 8;
    localparam int WIDE_W = 10;

    typedef logic [SMP_W-1:0]         smp_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    // Absolute value of a wide signed difference.
    function automatic wide_t mag(input wide_t v);
        return (v < 0) ? -v : v;
    endfunction

    // Widen an unsigned byte to the signed difference width.
    function automatic wide_t widen(input smp_t s);
        return wide_t'({2'b00, s});
    endfunction
endpackage

// File: rtl/pwd_sched.sv
// Anti-diagonal scheduler.
// Counts the cycles of one tile. It enables the row lane whose column lies on
// the current anti-diagonal, in the even cycles only, and raises done
// for one cycle at the end. A start while busy is ignored.
module pwd_sched #(
    parameter int DIM = 8,
    parameter int CIW = 3,
    parameter int CW  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic                load_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [DIM-1:0]      act_o,
    output logic [DIM*CIW-1:0]  col_o
);
    localparam int DIAGS    = 2*DIM - 1;
    localparam int LAST_CYC = 2*DIAGS - 1;

    logic [CW-1:0] cyc_q;
    logic          busy_q;
    logic          done_q;

    // Accept a start only when idle.
    assign load_o = start_i && !busy_q;

    // Cycle counter, busy flag and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                busy_q <= 1'b1;
                cyc_q  <= '0;
            end else if (busy_q) begin
                if (int'(cyc_q) == LAST_CYC) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end
        end
    end

    // Per-lane enable and column on the current anti-diagonal.
    always_comb begin
        int diag;
        diag = int'(cyc_q >> 1);
        for (int r = 0; r < DIM; r++) begin
            int col;
            col = diag - r;
            act_o[r] = busy_q && !cyc_q[0] && (col >= 0) && (col < DIM);
            col_o[r*CIW +: CIW] = (col >= 0 && col < DIM) ? CIW'(col) : '0;
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && int'(cyc_q) != LAST_CYC) |=> (busy_q && cyc_q == $past(cyc_q) + 1'b1));
    p_lane_onehot_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q[0] |-> act_o == '0);
endmodule

// File: rtl/pwd_lane.sv
// One Paeth predictor lane, two cycles per sample.
// Stage 1 registers the neighbours, the residual and the three absolute
// differences. Stage 2 picks the prediction in the fixed order a, b, c and
// adds the residual. Assumes that act_i is never high in two cycles in a row.
module pwd_lane
    import pwd_pkg::*;
#(
    parameter int CIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           act_i,
    input  logic [CIW-1:0] col_i,
    input  smp_t           a_i,
    input  smp_t           b_i,
    input  smp_t           c_i,
    input  smp_t           res_i,
    output logic           wr_o,
    output logic [CIW-1:0] col_o,
    output smp_t           smp_o
);
    logic           v_q;
    logic [CIW-1:0] col_q;
    smp_t           a_q, b_q, c_q, res_q;
    wide_t          da_q, db_q, dc_q;
    smp_t           pred;

    // Stage 1: capture the operands and the distances of the estimate to a, b and c.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            col_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            res_q <= '0;
            da_q  <= '0;
            db_q  <= '0;
            dc_q  <= '0;
        end else begin
            v_q <= act_i;
            if (act_i) begin
                col_q <= col_i;
                a_q   <= a_i;
                b_q   <= b_i;
                c_q   <= c_i;
                res_q <= res_i;
                da_q  <= mag(widen(b_i) - widen(c_i));
                db_q  <= mag(widen(a_i) - widen(c_i));
                dc_q  <= mag(widen(a_i) + widen(b_i) - widen(c_i) - widen(c_i));
            end
        end
    end

    // Stage 2: select the prediction with the fixed tie order and add the residual.
    always_comb begin
        if (da_q <= db_q && da_q <= dc_q) pred = a_q;
        else if (db_q <= dc_q)            pred = b_q;
        else                              pred = c_q;
        smp_o = res_q + pred;
    end

    assign wr_o  = v_q;
    assign col_o = col_q;

    p_wr_follows_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> wr_o);
    p_wr_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (da_q >= 0 && db_q >= 0 && dc_q >= 0));
endmodule

// File: rtl/paeth_wave_decoder.sv
// Paeth wavefront block decoder, top level.
// Captures a DIM x DIM tile of residuals on an accepted start, runs one
// lane per row along anti-diagonals, and writes each rebuilt sample into the
// output tile register. Neighbours outside the tile read as zero.
module paeth_wave_decoder
    import pwd_pkg::*;
#(
    parameter int DIM = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [DIM*DIM*SMP_W-1:0] resid_i,
    output logic [DIM*DIM*SMP_W-1:0] tile_o,
    output logic                     done_o
);
    localparam int CIW = (DIM > 1) ? $clog2(DIM) : 1;
    localparam int CW  = $clog2(4*DIM);

    logic                     load, busy;
    logic [DIM-1:0]           act, wr;
    logic [DIM*CIW-1:0]       act_col;
    logic [CIW-1:0]           wcol [DIM];
    smp_t                     nb_a [DIM];
    smp_t                     nb_b [DIM];
    smp_t                     nb_c [DIM];
    smp_t                     res  [DIM];
    smp_t                     smp  [DIM];
    smp_t                     tile_q  [DIM][DIM];
    smp_t                     resid_q [DIM][DIM];

    pwd_sched #(.DIM(DIM), .CIW(CIW), .CW(CW)) sched_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load), .busy_o(busy), .done_o(done_o),
        .act_o(act), .col_o(act_col)
    );

    // Residual capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++)
                    resid_q[r][c] <= '0;
        end else if (load) begin
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++)
                    resid_q[r][c] <= resid_i[(r*DIM+c)*SMP_W +: SMP_W];
        end
    end

    // Tile register: each lane writes its rebuilt sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++)
                    tile_q[r][c] <= '0;
        end else begin
            for (int r = 0; r < DIM; r++)
                if (wr[r]) tile_q[r][wcol[r]] <= smp[r];
        end
    end

    for (genvar r = 0; r < DIM; r++) begin : g_lane
        logic [CIW-1:0] col;
        assign col = act_col[r*CIW +: CIW];

        // Neighbour fetch with zero outside the tile.
        if (r == 0) begin : g_top
            always_comb begin
                nb_a[r] = (col != '0) ? tile_q[r][col - 1'b1] : '0;
                nb_b[r] = '0;
                nb_c[r] = '0;
                res[r]  = resid_q[r][col];
            end
        end else begin : g_inner
            always_comb begin
                nb_a[r] = (col != '0) ? tile_q[r][col - 1'b1]   : '0;
                nb_b[r] = tile_q[r-1][col];
                nb_c[r] = (col != '0) ? tile_q[r-1][col - 1'b1] : '0;
                res[r]  = resid_q[r][col];
            end
        end

        pwd_lane #(.CIW(CIW)) lane_i (
            .clk(clk), .rst_n(rst_n), .act_i(act[r]), .col_i(col),
            .a_i(nb_a[r]), .b_i(nb_b[r]), .c_i(nb_c[r]), .res_i(res[r]),
            .wr_o(wr[r]), .col_o(wcol[r]), .smp_o(smp[r])
        );

        for (genvar c = 0; c < DIM; c++) begin : g_out
            assign tile_o[(r*DIM+c)*SMP_W +: SMP_W] = tile_q[r][c];
        end
    end

    p_wr_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr) |-> (busy || done_o));
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);
    p_resid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(resid_q[0][0]));
endmodule

// File: tb/paeth_wave_decoder_tb.sv
// Self-checking bench: seeded random and directed tiles, compared with a serial model.
module paeth_wave_decoder_tb_top;
    localparam int DIM = 8;
    localparam int NB  = DIM*DIM*8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] resid = '0;
    logic [NB-1:0] tile;
    logic          done;
    int            errors = 0;
    int            checks = 0;
    logic [NB-1:0] prev_exp = '0;

    always #10 clk = ~clk;

    paeth_wave_decoder #(.DIM(DIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .resid_i(resid), .tile_o(tile), .done_o(done)
    );

    function automatic logic [7:0] pick(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        int p, pa, pb, pc;
        p  = int'(a) + int'(b) - int'(c);
        pa = (p > int'(a)) ? p - int'(a) : int'(a) - p;
        pb = (p > int'(b)) ? p - int'(b) : int'(b) - p;
        pc = (p > int'(c)) ? p - int'(c) : int'(c) - p;
        if (pa <= pb && pa <= pc) return a;
        else if (pb <= pc)        return b;
        else                      return c;
    endfunction

    function automatic logic [NB-1:0] model(input logic [NB-1:0] rs);
        logic [NB-1:0] o;
        o = '0;
        for (int r = 0; r < DIM; r++) begin
            for (int c = 0; c < DIM; c++) begin
                logic [7:0] a, b, cc;
                a  = (c > 0) ? o[(r*DIM+c-1)*8 +: 8] : 8'h00;
                b  = (r > 0) ? o[((r-1)*DIM+c)*8 +: 8] : 8'h00;
                cc = (r > 0 && c > 0) ? o[((r-1)*DIM+c-1)*8 +: 8] : 8'h00;
                o[(r*DIM+c)*8 +: 8] = rs[(r*DIM+c)*8 +: 8] + pick(a, b, cc);
            end
        end
        return o;
    endfunction

    task automatic check(input bit ok, input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one tile. If mid_start is set, pulse start with other residuals at edge 9.
    task automatic run_tile(input logic [NB-1:0] rs, input bit mid_start, input string tag);
        logic [NB-1:0] exp;
        exp = model(rs);
        @(negedge clk);
        resid = rs;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        resid = ~rs;  // R7: later changes on resid_i have no effect
        for (int k = 1; k <= 30; k++) begin
            if (mid_start && k == 9) start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (k == 1)
                check(tile[7:0] == prev_exp[7:0], {"R4 first sample early ", tag}, NB'(tile[7:0]), NB'(prev_exp[7:0]));
            if (k == 2)
                check(tile[7:0] == exp[7:0], {"R4 first sample at edge 2 ", tag}, NB'(tile[7:0]), NB'(exp[7:0]));
            if (k == 29)
                check(tile[NB-1 -: 8] == prev_exp[NB-1 -: 8], {"R4 last sample early ", tag},
                      NB'(tile[NB-1 -: 8]), NB'(prev_exp[NB-1 -: 8]));
            if (k == 29 || k == 30)
                check(done == (k == 30), {"R5 done timing ", tag}, NB'(done), NB'(k == 30));
        end
        check(tile == exp, {"R2 R3 R7 tile ", tag}, tile, exp);
        prev_exp = exp;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NB-1:0] rs;
        logic [NB-1:0] exp;
        int unused;
        unused = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tile == '0, "R1 reset tile", tile, '0);
        check(done == 1'b0, "R1 reset done", NB'(done), '0);

        run_tile('0, 1'b0, "zeros R3");
        run_tile({NB{1'b1}}, 1'b0, "all-ff R2");
        // Single corner residual: only edge propagation (R3).
        rs = '0; rs[7:0] = 8'd77;
        run_tile(rs, 1'b0, "corner R3");

        // Smooth ramps of small residuals.
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < DIM*DIM; i++) rs[i*8 +: 8] = 8'($urandom % 4);
            run_tile(rs, 1'b0, "smooth R2");
        end
        // Fully random tiles.
        for (int t = 0; t < 12; t++) begin
            for (int i = 0; i < DIM*DIM; i++) rs[i*8 +: 8] = 8'($urandom);
            run_tile(rs, 1'b0, "random R2");
        end
        // R6: a start during a tile is ignored (run_tile drives resid to ~rs then).
        for (int i = 0; i < DIM*DIM; i++) rs[i*8 +: 8] = 8'($urandom);
        run_tile(rs, 1'b1, "mid start R6");

        // R8: back-to-back start in the done cycle, then hold.
        for (int i = 0; i < DIM*DIM; i++) rs[i*8 +: 8] = 8'($urandom);
        exp = model(rs);
        resid = rs;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (30) begin @(posedge clk); @(negedge clk); end
        check(done == 1'b1, "R8 back-to-back done", NB'(done), NB'(1));
        check(tile == exp, "R8 back-to-back tile", tile, exp);
        repeat (5) begin @(posedge clk); @(negedge clk); end
        check(tile == exp, "R8 tile held", tile, exp);
        check(done == 1'b0, "R5 done single cycle", NB'(done), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule